// File: doc/BRIEF.md
# String Copy Address Sequencer

This block drives a repeated memory-to-memory copy, one element at a time. A start pulse loads three working registers: a source index, a destination index and a repeat count. It also latches the transfer settings:
- the element size: byte, word or doubleword;
- the address width: 16 or 32 bits;
- the direction;
- whether the copy repeats;
- whether an alternate base replaces the normal source segment base.

For every element the block issues a read request at source base plus source index. It waits for the read data, then issues a write request carrying that data to the destination base plus the destination index. The destination base can never be replaced. Once the write is accepted, both indexes step by the element size, up or down, and the count steps down by one.

The read request, the read response and the write request are valid/ready channels. A request stays asserted with stable address, size and data until its ready is seen high at a clock edge. The only exception is that an abort may withdraw a pending request. The sequencer raises its response ready only while it waits for read data. The memory side may hold any ready low for as long as it needs. Each element takes at least three cycles: request, response, write. An abort input ends a copy early without signalling completion. The working registers are visible at the ports throughout.

Top module: `strmv_seq`

## Requirements
- R1: During and after reset, before any start, busy, done, rd_valid, wr_valid and rsp_ready are 0.
- R2: The read address is the source base plus the effective source index. The source base is ovr_base when ovr_en was 1 at start, and ds_base otherwise. The write address is always es_base plus the effective destination index. In 32-bit mode (addr32=1) the effective index is the full index. In 16-bit mode it is the low 16 bits, zero-extended.
- R3: The step is 1, 2 or 4 for op_size codes 0, 1 and 2, and code 3 also steps by 4. After each element both indexes add the step when dir_dn=0 and subtract it when dir_dn=1.
- R4: In 16-bit mode, index and count updates wrap modulo 2^16 and leave bits 31:16 unchanged. The count is treated as zero when its low 16 bits are zero.
- R5: Each element is one read handshake, then one response handshake, then one write handshake. The write carries the response data, and rd_size and wr_size carry the latched op_size. rd_valid and wr_valid are never high together.
- R6: si_out, di_out and cnt_out change while busy only in the cycle after a write handshake.
- R7: With rep_en=1, the block moves exactly as many elements as the effective count and decrements the count once per element. done pulses for one cycle in the cycle after the last write handshake, and busy is then 0.
- R8: With rep_en=1 and an effective count of zero, no request is issued and done pulses in the cycle after start.
- R9: With rep_en=0, exactly one element is moved whatever the count, and the count is left unchanged.
- R10: A request held off by a low ready stays valid with a stable address, size and data.
- R11: abort while busy returns the block to idle without a done pulse. If a write is accepted in the same cycle, that element still commits its index and count update.
- R12: start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| op_size | input | 2 | Element size code: 0 byte, 1 word, 2 or 3 doubleword |
| addr32 | input | 1 | 1: 32-bit indexes, 0: 16-bit indexes |
| dir_dn | input | 1 | 1: indexes step downward |
| rep_en | input | 1 | Repeat by count |
| ovr_en | input | 1 | Use ovr_base for the source |
| ovr_base | input | 32 | Alternate source base |
| ds_base | input | 32 | Normal source base |
| es_base | input | 32 | Destination base |
| si_init | input | 32 | Source index loaded at start |
| di_init | input | 32 | Destination index loaded at start |
| cnt_init | input | 32 | Count loaded at start |
| abort | input | 1 | Stop the copy early |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | 32 | Current source index |
| di_out | output | 32 | Current destination index |
| cnt_out | output | 32 | Current count |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read address |
| rd_size | output | 2 | Read size code |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Sequencer waits for read data |
| rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data |

## Verification
The two functions that can meet in one cycle are the commit of an element on a write handshake and an abort. To provoke this, the bench holds wr_ready low until the second write is pending and then raises wr_ready and abort together for a single cycle. It judges the outcome at the ports. The indexes and count must show exactly two committed elements, busy must drop, and no done pulse may appear. Random ready stalls separately exercise the hold rules of each channel while a repeated copy runs.

// File: rtl/strmv_pkg.sv
package strmv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_RSP  = 2'd2,
    ST_WR   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [1:0] size;
    logic       wide;
    logic       dn;
    logic       rep;
    logic       ovr;
  } xfer_cfg_t;

  // element byte count from the size code
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 3'd1;
      2'd1:    size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/strmv_idx_unit.sv
module strmv_idx_unit #(
  parameter int IW = 32,
  parameter int NW = 16
) (
  input  logic [IW-1:0] cur,
  input  logic [2:0]    step,
  input  logic          dn,
  input  logic          wide,
  output logic [IW-1:0] eff,
  output logic [IW-1:0] nxt,
  output logic          eff_zero,
  output logic          nxt_zero
);
  localparam int UW = IW - NW;

  logic [IW-1:0] step_w;
  logic [IW-1:0] full_nx;
  logic [NW-1:0] step_n;
  logic [NW-1:0] low_nx;

  assign step_w  = IW'(step);
  assign step_n  = NW'(step);
  assign full_nx = dn ? (cur - step_w) : (cur + step_w);
  assign low_nx  = dn ? (cur[NW-1:0] - step_n) : (cur[NW-1:0] + step_n);

  generate
    if (UW > 0) begin : g_split
      assign eff      = wide ? cur : {{UW{1'b0}}, cur[NW-1:0]};
      assign nxt      = wide ? full_nx : {cur[IW-1:NW], low_nx};
      assign eff_zero = wide ? (cur == '0) : (cur[NW-1:0] == '0);
      assign nxt_zero = wide ? (full_nx == '0) : (low_nx == '0);
    end else begin : g_flat
      assign eff      = cur;
      assign nxt      = full_nx;
      assign eff_zero = (cur == '0);
      assign nxt_zero = (full_nx == '0);
    end
  endgenerate

endmodule

// File: rtl/strmv_addr_gen.sv
module strmv_addr_gen #(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          ovr_sel,
  input  logic [AW-1:0] ovr_base,
  input  logic [AW-1:0] ds_base,
  input  logic [AW-1:0] es_base,
  input  logic [IW-1:0] src_eff,
  input  logic [IW-1:0] dst_eff,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  logic [AW-1:0] src_base;

  // only the source side may take the alternate base
  assign src_base = ovr_sel ? ovr_base : ds_base;
  assign src_addr = src_base + AW'(src_eff);
  assign dst_addr = es_base + AW'(dst_eff);

endmodule

// File: rtl/strmv_ctrl.sv
module strmv_ctrl
  import strmv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_rep,
  input  logic       start_zero,
  input  logic       abort,
  input  logic       rd_hs,
  input  logic       rsp_hs,
  input  logic       wr_hs,
  input  logic       last_elem,
  output seq_state_e state,
  output logic       load,
  output logic       done
);
  seq_state_e state_nx;
  logic       done_nx;

  always_comb begin
    state_nx = state;
    done_nx  = 1'b0;
    load     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (start_rep && start_zero) done_nx = 1'b1;
          else                         state_nx = ST_RD;
        end
      end
      ST_RD: begin
        if (abort)      state_nx = ST_IDLE;
        else if (rd_hs) state_nx = ST_RSP;
      end
      ST_RSP: begin
        if (abort)       state_nx = ST_IDLE;
        else if (rsp_hs) state_nx = ST_WR;
      end
      ST_WR: begin
        if (wr_hs) begin
          if (abort) begin
            state_nx = ST_IDLE;
          end else if (last_elem) begin
            state_nx = ST_IDLE;
            done_nx  = 1'b1;
          end else begin
            state_nx = ST_RD;
          end
        end else if (abort) begin
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= done_nx;
    end
  end

endmodule

// File: rtl/strmv_seq.sv
module strmv_seq
  import strmv_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IW     = 32,
  parameter int DW     = 32,
  parameter int NARROW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_size,
  input  logic          addr32,
  input  logic          dir_dn,
  input  logic          rep_en,
  input  logic          ovr_en,
  input  logic [AW-1:0] ovr_base,
  input  logic [AW-1:0] ds_base,
  input  logic [AW-1:0] es_base,
  input  logic [IW-1:0] si_init,
  input  logic [IW-1:0] di_init,
  input  logic [IW-1:0] cnt_init,
  input  logic          abort,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] si_out,
  output logic [IW-1:0] di_out,
  output logic [IW-1:0] cnt_out,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [DW-1:0] wr_data
);
  localparam int NUNIT = 3;
  localparam int U_SRC = 0;
  localparam int U_DST = 1;
  localparam int U_CNT = 2;

  seq_state_e state;
  xfer_cfg_t  cfg_q;
  logic [IW-1:0] si_q, di_q, cnt_q;
  logic [DW-1:0] data_q;
  logic          load, commit, rd_hs, rsp_hs, wr_hs;
  logic [2:0]    cfg_step;

  logic [IW-1:0] u_cur  [NUNIT];
  logic [2:0]    u_step [NUNIT];
  logic          u_dn   [NUNIT];
  logic [IW-1:0] u_eff  [NUNIT];
  logic [IW-1:0] u_nxt  [NUNIT];
  logic          u_ez   [NUNIT];
  logic          u_nz   [NUNIT];

  logic [IW-1:0] init_eff, init_nxt;
  logic          init_zero, init_nz_unused;

  assign cfg_step = size_step(cfg_q.size);

  assign u_cur[U_SRC]  = si_q;
  assign u_cur[U_DST]  = di_q;
  assign u_cur[U_CNT]  = cnt_q;
  assign u_step[U_SRC] = cfg_step;
  assign u_step[U_DST] = cfg_step;
  assign u_step[U_CNT] = 3'd1;
  assign u_dn[U_SRC]   = cfg_q.dn;
  assign u_dn[U_DST]   = cfg_q.dn;
  assign u_dn[U_CNT]   = 1'b1;

  // one wrap-aware stepping unit per working register
  generate
    for (genvar g = 0; g < NUNIT; g++) begin : g_unit
      strmv_idx_unit #(.IW(IW), .NW(NARROW)) u_idx (
        .cur      (u_cur[g]),
        .step     (u_step[g]),
        .dn       (u_dn[g]),
        .wide     (cfg_q.wide),
        .eff      (u_eff[g]),
        .nxt      (u_nxt[g]),
        .eff_zero (u_ez[g]),
        .nxt_zero (u_nz[g])
      );
    end
  endgenerate

  // zero test of the count being loaded, in the requested address width
  strmv_idx_unit #(.IW(IW), .NW(NARROW)) u_init_cnt (
    .cur      (cnt_init),
    .step     (3'd1),
    .dn       (1'b1),
    .wide     (addr32),
    .eff      (init_eff),
    .nxt      (init_nxt),
    .eff_zero (init_zero),
    .nxt_zero (init_nz_unused)
  );

  strmv_addr_gen #(.AW(AW), .IW(IW)) u_addr (
    .ovr_sel  (cfg_q.ovr),
    .ovr_base (ovr_base),
    .ds_base  (ds_base),
    .es_base  (es_base),
    .src_eff  (u_eff[U_SRC]),
    .dst_eff  (u_eff[U_DST]),
    .src_addr (rd_addr),
    .dst_addr (wr_addr)
  );

  assign rd_valid  = (state == ST_RD);
  assign rsp_ready = (state == ST_RSP);
  assign wr_valid  = (state == ST_WR);
  assign busy      = (state != ST_IDLE);
  assign rd_hs     = rd_valid && rd_ready;
  assign rsp_hs    = rsp_valid && rsp_ready;
  assign wr_hs     = wr_valid && wr_ready;
  assign commit    = wr_hs;

  strmv_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_rep  (rep_en),
    .start_zero (init_zero),
    .abort      (abort),
    .rd_hs      (rd_hs),
    .rsp_hs     (rsp_hs),
    .wr_hs      (wr_hs),
    .last_elem  (!cfg_q.rep || u_nz[U_CNT]),
    .state      (state),
    .load       (load),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      si_q   <= '0;
      di_q   <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      if (load) begin
        cfg_q.size <= op_size;
        cfg_q.wide <= addr32;
        cfg_q.dn   <= dir_dn;
        cfg_q.rep  <= rep_en;
        cfg_q.ovr  <= ovr_en;
        si_q       <= si_init;
        di_q       <= di_init;
        cnt_q      <= cnt_init;
      end
      if (rsp_hs) data_q <= rsp_data;
      if (commit) begin
        si_q <= u_nxt[U_SRC];
        di_q <= u_nxt[U_DST];
        if (cfg_q.rep) cnt_q <= u_nxt[U_CNT];
      end
    end
  end

  assign si_out  = si_q;
  assign di_out  = di_q;
  assign cnt_out = cnt_q;
  assign rd_size = cfg_q.size;
  assign wr_size = cfg_q.size;
  assign wr_data = data_q;

endmodule

// File: rtl/strmv_seq_chk.sv
module strmv_seq_chk
  import strmv_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DW = 32,
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          busy,
  input logic          done,
  input logic [IW-1:0] si_out,
  input logic [IW-1:0] di_out,
  input logic [IW-1:0] cnt_out,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    cfg_size,
  input logic          cfg_wide,
  input logic          cfg_dn,
  input logic          cfg_rep
);
  logic          wr_hs;
  logic [IW-1:0] stp;
  assign wr_hs = wr_valid && wr_ready;
  assign stp   = IW'(size_step(cfg_size));

  assert_excl_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !abort) |=> (rd_valid && $stable(rd_addr)));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !abort) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_idx_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_hs) |=> ($stable(si_out) && $stable(di_out) && $stable(cnt_out)));

  assert_step_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && cfg_wide) |=> ($past(cfg_dn) ? (($past(si_out) - si_out) == $past(stp))
                                           : ((si_out - $past(si_out)) == $past(stp))));

  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !cfg_wide) |=> ((si_out[IW-1:NW] == $past(si_out[IW-1:NW])) &&
                             (di_out[IW-1:NW] == $past(di_out[IW-1:NW])) &&
                             (cnt_out[IW-1:NW] == $past(cnt_out[IW-1:NW]))));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !cfg_rep) |=> (!busy && (cnt_out == $past(cnt_out))));

  assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !done);

endmodule

bind strmv_seq strmv_seq_chk #(.AW(AW), .IW(IW), .DW(DW), .NW(NARROW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort    (abort),
  .busy     (busy),
  .done     (done),
  .si_out   (si_out),
  .di_out   (di_out),
  .cnt_out  (cnt_out),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .cfg_size (cfg_q.size),
  .cfg_wide (cfg_q.wide),
  .cfg_dn   (cfg_q.dn),
  .cfg_rep  (cfg_q.rep)
);

// File: tb/sim_strmv_seq.sv
`timescale 1ns/1ps
module sim_strmv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic        addr32 = 1'b1, dir_dn = 1'b0, rep_en = 1'b0, ovr_en = 1'b0;
  logic [31:0] ovr_base = 32'h3000_0000;
  logic [31:0] ds_base  = 32'h1000_0000;
  logic [31:0] es_base  = 32'h2000_0000;
  logic [31:0] si_init = '0, di_init = '0, cnt_init = '0;
  logic        abort = 1'b0;
  logic        busy, done;
  logic [31:0] si_out, di_out, cnt_out;
  logic        rd_valid, rsp_ready, wr_valid;
  logic        rd_ready = 1'b0, rsp_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] rsp_data = '0;
  logic [1:0]  rd_size, wr_size;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  strmv_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size), .addr32(addr32),
    .dir_dn(dir_dn), .rep_en(rep_en), .ovr_en(ovr_en), .ovr_base(ovr_base),
    .ds_base(ds_base), .es_base(es_base), .si_init(si_init), .di_init(di_init),
    .cnt_init(cnt_init), .abort(abort), .busy(busy), .done(done),
    .si_out(si_out), .di_out(di_out), .cnt_out(cnt_out),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data)
  );

  // memory responder and transaction log
  logic        stall_en = 1'b0, wr_hold = 1'b0, wr_force = 1'b0, clr_log = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [31:0] rd_log [16];
  logic [31:0] wa_log [16];
  logic [31:0] wd_log [16];
  logic [1:0]  ws_log [16];
  int n_rd = 0, n_wr = 0, n_done = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  always @(posedge clk) begin
    if (clr_log) begin
      n_rd <= 0; n_wr <= 0; n_done <= 0; pend <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) pend <= 1'b0;
      if (rd_valid && rd_ready) begin
        if (n_rd < 16) rd_log[n_rd] <= rd_addr;
        n_rd <= n_rd + 1; pend <= 1'b1; pend_addr <= rd_addr;
      end
      if (wr_valid && wr_ready) begin
        if (n_wr < 16) begin
          wa_log[n_wr] <= wr_addr; wd_log[n_wr] <= wr_data; ws_log[n_wr] <= wr_size;
        end
        n_wr <= n_wr + 1;
      end
      if (done) n_done <= n_done + 1;
    end
  end

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready  <= stall_en ? lfsr[0] : 1'b1;
    rsp_valid <= pend && (stall_en ? lfsr[3] : 1'b1);
    rsp_data  <= memf(pend_addr);
    wr_ready  <= wr_hold ? wr_force : (stall_en ? lfsr[5] : 1'b1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] eidx(input logic [31:0] v, input bit a32);
    return a32 ? v : {16'h0, v[15:0]};
  endfunction

  function automatic logic [31:0] nidx(input logic [31:0] v, input int st,
                                       input bit dn, input bit a32);
    logic [31:0] f;
    logic [15:0] l;
    f = dn ? v - 32'(st) : v + 32'(st);
    l = dn ? v[15:0] - 16'(st) : v[15:0] + 16'(st);
    return a32 ? f : {v[31:16], l};
  endfunction

  task automatic clear_log();
    @(posedge clk); #1 clr_log = 1'b1;
    @(posedge clk); #1 clr_log = 1'b0;
  endtask

  task automatic kick(input logic [31:0] si, input logic [31:0] di, input logic [31:0] cnt,
                      input logic [1:0] sz, input bit a32, input bit dn,
                      input bit rep, input bit ovr);
    @(negedge clk);
    si_init = si; di_init = di; cnt_init = cnt; op_size = sz;
    addr32 = a32; dir_dn = dn; rep_en = rep; ovr_en = ovr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [31:0] si, input logic [31:0] di,
                          input logic [31:0] cnt, input logic [1:0] sz, input bit a32,
                          input bit dn, input bit rep, input bit ovr,
                          input int exp_n, input bit poke);
    int st;
    logic [31:0] s, d, c, ea;
    clear_log();
    kick(si, di, cnt, sz, a32, dn, rep, ovr);
    if (poke) begin
      // R12: second start while busy must be ignored
      start = 1'b1; si_init = 32'hDEAD_0000; cnt_init = 32'd9;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 4000 && busy; w++) @(negedge clk);
    @(negedge clk);
    st = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    chk({tag, " R7 element count"}, 32'(n_wr), 32'(exp_n));
    chk({tag, " R5 read count"}, 32'(n_rd), 32'(exp_n));
    chk({tag, " R7 single done"}, 32'(n_done), 32'd1);
    s = si; d = di; c = cnt;
    for (int k = 0; k < exp_n && k < 16; k++) begin
      ea = (ovr ? ovr_base : ds_base) + eidx(s, a32);
      chk({tag, " R2 read address"}, rd_log[k], ea);
      chk({tag, " R2 write address"}, wa_log[k], es_base + eidx(d, a32));
      chk({tag, " R5 write data"}, wd_log[k], memf(ea));
      chk({tag, " R5 write size"}, 32'(ws_log[k]), 32'(sz));
      s = nidx(s, st, dn, a32);
      d = nidx(d, st, dn, a32);
      if (rep) c = nidx(c, 1, 1'b1, a32);
    end
    chk({tag, " R3 final source index"}, si_out, s);
    chk({tag, " R3 final destination index"}, di_out, d);
    chk({tag, " R7 final count"}, cnt_out, c);
    chk({tag, " R7 idle after done"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 wr_valid after reset", 32'(wr_valid), 32'd0);
    chk("R1 rsp_ready after reset", 32'(rsp_ready), 32'd0);
  endtask

  task automatic t_zero(input string tag, input logic [31:0] cnt, input bit a32);
    clear_log();
    kick(32'h40, 32'h80, cnt, 2'd2, a32, 1'b0, 1'b1, 1'b0);
    // start taken at the edge before this negedge: done now high
    chk({tag, " R8 done next cycle"}, 32'(done), 32'd1);
    chk({tag, " R8 not busy"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " R8 no reads"}, 32'(n_rd), 32'd0);
    chk({tag, " R8 count kept"}, cnt_out, cnt);
  endtask

  task automatic t_abort();
    clear_log();
    wr_hold = 1'b1; wr_force = 1'b0;
    kick(32'h100, 32'h200, 32'd5, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    for (int w = 0; w < 200 && !wr_valid; w++) begin @(posedge clk); #1; end
    wr_force = 1'b1;
    @(posedge clk); #1 wr_force = 1'b0;
    for (int w = 0; w < 200 && !wr_valid; w++) begin @(posedge clk); #1; end
    // write acceptance and abort land in the same cycle
    wr_force = 1'b1; abort = 1'b1;
    @(posedge clk); #1 wr_force = 1'b0; abort = 1'b0;
    repeat (4) @(negedge clk);
    wr_hold = 1'b0;
    chk("R11 busy cleared", 32'(busy), 32'd0);
    chk("R11 no done pulse", 32'(n_done), 32'd0);
    chk("R11 writes committed", 32'(n_wr), 32'd2);
    chk("R11 source index", si_out, 32'h108);
    chk("R11 destination index", di_out, 32'h208);
    chk("R11 count", cnt_out, 32'd3);
  endtask

  initial begin
    t_reset();
    run_case("dword up", 32'h0000_0010, 32'h0000_0100, 32'd3, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3, 1'b0);
    stall_en = 1'b1;
    run_case("word down stalled R10", 32'h0000_0400, 32'h0000_0800, 32'd4, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 4, 1'b0);
    stall_en = 1'b0;
    run_case("byte wrap16 R4", 32'h1234_0001, 32'hABCD_0000, 32'hFFFF_0002, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2, 1'b0);
    run_case("word wrap16 up R4", 32'h0001_FFFE, 32'h0002_FFFF, 32'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0);
    run_case("size3 R3", 32'h0000_0020, 32'h0000_0030, 32'd2, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2, 1'b0);
    run_case("no repeat R9", 32'h0000_0050, 32'h0000_0060, 32'd7, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    run_case("no repeat zero count R9", 32'h0000_0070, 32'h0000_0090, 32'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    run_case("restart ignored R12", 32'h0000_0500, 32'h0000_0600, 32'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2, 1'b1);
    t_zero("zero32", 32'd0, 1'b1);
    t_zero("zero16 R4", 32'h0001_0000, 1'b0);
    t_abort();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule